// File: doc/BRIEF.md
# External Interrupt Sense Unit

This block turns four external interrupt pins into interrupt request lines for a processor core. Each pin has a two-bit sense code in a shared control byte. The code selects one of four modes: low level, any change, falling edge or rising edge. The pins are resynchronized to the system clock. Edges are found by comparing two successive synchronized samples.

In the three edge modes a detected event sets a sticky per-pin flag. The core clears that flag with an acknowledge strobe, or software clears it by writing a one to the flag bit. In low-level mode no flag is kept, and the request follows the synchronized pin. A request leaves the block only while the global enable and that pin's mask bit are both set. Mask changes and mode changes act at once, with no filtering. Rewriting a sense code while the pin is unmasked can therefore raise a request the software did not expect.

Top module: `irq_sense_unit`

## Requirements
- R1: After reset the control byte, the mask and all flags read as zero, and every `irq_req` bit is low.
- R2: A write with `wr_sel` 0 loads the control byte and `wr_sel` 1 loads the mask from the low bits. A write with `wr_sel` 2 clears each flag whose `wr_data` bit is one. A read with `rd_sel` 0, 1 or 2 returns the control byte, the mask or the flags, and any value written to the control byte reads back unchanged.
- R3: Pin i is controlled by control bits [2i+1:2i]. Code 00 selects low level, 01 any change, 10 falling edge and 11 rising edge.
- R4: Each pin passes through two synchronizer flops and then a sample register. A pin change driven between clock edges sets the flag on the third rising edge after it. No flag is ever set without a detected event.
- R5: In low-level mode the request rises two edges after the pin goes low and falls two edges after the pin returns high. No flag is set in this mode.
- R6: In any-change mode, a rising pin transition sets the flag, and so does a falling one.
- R7: Falling mode sets the flag only on a high-to-low transition. Rising mode sets it only on a low-to-high transition.
- R8: A pulse held across a rising clock edge is detected. A pulse that starts and ends between two rising edges leaves the flags unchanged.
- R9: A flag stays set until `ack_vec` or a flag-clear write clears it. If an event and a clear reach the same flag in the same cycle, the flag is set.
- R10: `irq_req[i]` is high only while `gie` and mask bit i are set. A masked event still sets its flag, so setting the mask later raises the request in the next cycle.
- R11: A new sense code acts from the cycle after the write. A pin held low under rising mode raises a request as soon as its code becomes 00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| pins_in | input | NPINS | External interrupt pins, asynchronous |
| gie | input | 1 | Global interrupt enable |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 2 | Write target: 0 control, 1 mask, 2 flag clear |
| wr_data | input | 2*NPINS | Write data |
| rd_sel | input | 2 | Read source: 0 control, 1 mask, 2 flags |
| rd_data | output | 2*NPINS | Read data, combinational |
| ack_vec | input | NPINS | Per-pin acknowledge, clears the flag |
| irq_req | output | NPINS | Gated interrupt requests |

## Verification
The assertions assume the following about the inputs:
- The pins sit at their idle high level through reset, so that the synchronizer and sample registers reset to ones without creating an edge.
- No write is issued while reset is asserted.

The bench honours both rules. It holds every pin high until reset is released, and it drives pins, writes and acknowledges only on falling clock edges. Each edge test first places the pin at its starting level under a mode that ignores that transition. It then clears the flags and only after that applies the transition under test.

// File: rtl/irq_sense_pkg.sv
package irq_sense_pkg;

    typedef enum logic [1:0] {
        SENSE_LOW  = 2'b00,
        SENSE_ANY  = 2'b01,
        SENSE_FALL = 2'b10,
        SENSE_RISE = 2'b11
    } sense_mode_e;

    typedef enum logic [1:0] {
        SEL_CTRL = 2'd0,
        SEL_MASK = 2'd1,
        SEL_FLAG = 2'd2,
        SEL_NONE = 2'd3
    } reg_sel_e;

    typedef struct packed {
        logic cur;
        logic prev;
    } pin_sample_t;

    function automatic logic edge_hit(sense_mode_e mode, pin_sample_t s);
        logic hit;
        case (mode)
            SENSE_ANY:  hit = s.cur ^ s.prev;
            SENSE_FALL: hit = s.prev & ~s.cur;
            SENSE_RISE: hit = ~s.prev & s.cur;
            default:    hit = 1'b0;
        endcase
        return hit;
    endfunction

endpackage

// File: rtl/irq_pin_sync.sv
module irq_pin_sync #(
    parameter int W       = 4,
    parameter int STAGES  = 2,
    parameter bit IDLE    = 1'b1
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] chain [STAGES];

    for (genvar s = 0; s < STAGES; s++) begin : g_stage
        always_ff @(posedge clk) begin
            if (rst)
                chain[s] <= {W{IDLE}};
            else if (s == 0)
                chain[s] <= d;
            else
                chain[s] <= chain[(s == 0) ? 0 : s-1];
        end
    end

    assign q = chain[STAGES-1];
endmodule

// File: rtl/irq_sense_regs.sv
module irq_sense_regs
    import irq_sense_pkg::*;
#(
    parameter int NPINS = 4,
    localparam int CW   = 2*NPINS
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_en,
    input  logic [1:0]       wr_sel,
    input  logic [CW-1:0]    wr_data,
    input  logic [1:0]       rd_sel,
    input  logic [NPINS-1:0] flag_q,
    output logic [CW-1:0]    rd_data,
    output logic [CW-1:0]    ctrl_q,
    output logic [NPINS-1:0] mask_q,
    output logic [NPINS-1:0] clr_wr
);
    reg_sel_e wsel, rsel;
    assign wsel = reg_sel_e'(wr_sel);
    assign rsel = reg_sel_e'(rd_sel);

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl_q <= '0;
            mask_q <= '0;
        end else if (wr_en) begin
            if (wsel == SEL_CTRL) ctrl_q <= wr_data;
            if (wsel == SEL_MASK) mask_q <= wr_data[NPINS-1:0];
        end
    end

    assign clr_wr = (wr_en && wsel == SEL_FLAG) ? wr_data[NPINS-1:0] : '0;

    always_comb begin
        rd_data = '0;
        case (rsel)
            SEL_CTRL: rd_data = ctrl_q;
            SEL_MASK: rd_data[NPINS-1:0] = mask_q;
            SEL_FLAG: rd_data[NPINS-1:0] = flag_q;
            default:  rd_data = '0;
        endcase
    end
endmodule

// File: rtl/irq_sense_lane.sv
module irq_sense_lane
    import irq_sense_pkg::*;
#(
    parameter bit IDLE = 1'b1
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        pin_sync,
    input  sense_mode_e mode,
    input  logic        mask,
    input  logic        gie,
    input  logic        clr,
    output logic        evt,
    output logic        flag_q,
    output logic        req
);
    pin_sample_t smp;
    logic        prev_q;

    always_ff @(posedge clk) begin
        if (rst) prev_q <= IDLE;
        else     prev_q <= pin_sync;
    end

    assign smp.cur  = pin_sync;
    assign smp.prev = prev_q;
    assign evt      = edge_hit(mode, smp);

    always_ff @(posedge clk) begin
        if (rst)
            flag_q <= 1'b0;
        else
            flag_q <= evt | (flag_q & ~clr);
    end

    logic pending;
    assign pending = (mode == SENSE_LOW) ? ~smp.cur : flag_q;
    assign req     = gie & mask & pending;
endmodule

// File: rtl/irq_sense_unit.sv
module irq_sense_unit
    import irq_sense_pkg::*;
#(
    parameter int NPINS       = 4,
    parameter int SYNC_STAGES = 2
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [NPINS-1:0]   pins_in,
    input  logic               gie,
    input  logic               wr_en,
    input  logic [1:0]         wr_sel,
    input  logic [2*NPINS-1:0] wr_data,
    input  logic [1:0]         rd_sel,
    output logic [2*NPINS-1:0] rd_data,
    input  logic [NPINS-1:0]   ack_vec,
    output logic [NPINS-1:0]   irq_req
);
    localparam bit IDLE_LVL = 1'b1;

    logic [NPINS-1:0]   pins_s;
    logic [2*NPINS-1:0] ctrl_q;
    logic [NPINS-1:0]   mask_q;
    logic [NPINS-1:0]   clr_wr;
    logic [NPINS-1:0]   clr_vec;
    logic [NPINS-1:0]   evt_vec;
    logic [NPINS-1:0]   flag_q;

    irq_pin_sync #(.W(NPINS), .STAGES(SYNC_STAGES), .IDLE(IDLE_LVL)) u_sync (
        .clk (clk),
        .rst (rst),
        .d   (pins_in),
        .q   (pins_s)
    );

    irq_sense_regs #(.NPINS(NPINS)) u_regs (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (wr_en),
        .wr_sel  (wr_sel),
        .wr_data (wr_data),
        .rd_sel  (rd_sel),
        .flag_q  (flag_q),
        .rd_data (rd_data),
        .ctrl_q  (ctrl_q),
        .mask_q  (mask_q),
        .clr_wr  (clr_wr)
    );

    assign clr_vec = clr_wr | ack_vec;

    for (genvar i = 0; i < NPINS; i++) begin : g_lane
        irq_sense_lane #(.IDLE(IDLE_LVL)) u_lane (
            .clk      (clk),
            .rst      (rst),
            .pin_sync (pins_s[i]),
            .mode     (sense_mode_e'(ctrl_q[2*i +: 2])),
            .mask     (mask_q[i]),
            .gie      (gie),
            .clr      (clr_vec[i]),
            .evt      (evt_vec[i]),
            .flag_q   (flag_q[i]),
            .req      (irq_req[i])
        );
    end
endmodule

// File: rtl/irq_sense_checker.sv
module irq_sense_checker #(
    parameter int NPINS = 4
) (
    input logic               clk,
    input logic               rst,
    input logic               gie,
    input logic [2*NPINS-1:0] ctrl_q,
    input logic [NPINS-1:0]   mask_q,
    input logic [NPINS-1:0]   evt_vec,
    input logic [NPINS-1:0]   clr_vec,
    input logic [NPINS-1:0]   flag_q,
    input logic [NPINS-1:0]   irq_req
);
    assert_ctrl_reset_R1: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (ctrl_q == '0 && mask_q == '0 && flag_q == '0));

    assert_req_gated_R10: assert property (@(posedge clk) disable iff (rst)
        (irq_req & ~({NPINS{gie}} & mask_q)) == '0);

    assert_flag_source_R4: assert property (@(posedge clk) disable iff (rst)
        (flag_q & ~$past(flag_q) & ~$past(evt_vec)) == '0);

    assert_flag_sticky_R9: assert property (@(posedge clk) disable iff (rst)
        ($past(flag_q) & ~flag_q & ~$past(clr_vec)) == '0);

    assert_set_wins_R9: assert property (@(posedge clk) disable iff (rst)
        (evt_vec != '0) |=> ((flag_q & $past(evt_vec)) == $past(evt_vec)));
endmodule

bind irq_sense_unit irq_sense_checker #(.NPINS(NPINS)) u_chk (
    .clk     (clk),
    .rst     (rst),
    .gie     (gie),
    .ctrl_q  (ctrl_q),
    .mask_q  (mask_q),
    .evt_vec (evt_vec),
    .clr_vec (clr_vec),
    .flag_q  (flag_q),
    .irq_req (irq_req)
);

// File: tb/sim_irq_sense_unit.sv
module sim_irq_sense_unit;
    localparam int CLK_PERIOD = 10;
    localparam int NP = 4;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic [NP-1:0] pins_in = '1;
    logic          gie = 1'b0;
    logic          wr_en = 1'b0;
    logic [1:0]    wr_sel = 2'd0;
    logic [7:0]    wr_data = '0;
    logic [1:0]    rd_sel = 2'd0;
    logic [7:0]    rd_data;
    logic [NP-1:0] ack_vec = '0;
    logic [NP-1:0] irq_req;

    int n_chk = 0;
    int n_bad = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    irq_sense_unit #(.NPINS(NP), .SYNC_STAGES(2)) u0 (
        .clk(clk), .rst(rst), .pins_in(pins_in), .gie(gie),
        .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
        .rd_sel(rd_sel), .rd_data(rd_data),
        .ack_vec(ack_vec), .irq_req(irq_req)
    );

    task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wr(input logic [1:0] sel, input logic [7:0] d);
        wr_en = 1'b1; wr_sel = sel; wr_data = d;
        cyc(1);
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic [1:0] sel, output logic [7:0] v);
        rd_sel = sel;
        #1;
        v = rd_data;
    endtask

    task automatic t_reset();
        logic [7:0] v;
        rd(2'd0, v); check("R1 ctrl after reset", v, 8'h00);
        rd(2'd1, v); check("R1 mask after reset", v, 8'h00);
        rd(2'd2, v); check("R1 flags after reset", v, 8'h00);
        check("R1 irq after reset", {4'h0, irq_req}, 8'h00);
    endtask

    task automatic t_regs();
        logic [7:0] v;
        wr(2'd0, 8'h9C); rd(2'd0, v); check("R2 ctrl readback 9C", v, 8'h9C);
        wr(2'd0, 8'h63); rd(2'd0, v); check("R2 ctrl readback 63", v, 8'h63);
        wr(2'd1, 8'h0A); rd(2'd1, v); check("R2 mask readback", v, 8'h0A);
        wr(2'd0, 8'h00); wr(2'd1, 8'h00);
    endtask

    task automatic t_level();
        logic [7:0] v;
        wr(2'd0, 8'h00); gie = 1'b1;
        for (int i = 0; i < NP; i++) begin
            wr(2'd1, 8'(1 << i));
            pins_in[i] = 1'b0;
            cyc(1); check($sformatf("R5 level lane%0d one edge", i), {4'h0, irq_req}, 8'h00);
            cyc(1); check($sformatf("R5 level lane%0d asserted", i), {4'h0, irq_req}, 8'(1 << i));
            cyc(3); check($sformatf("R5 level lane%0d held", i), {4'h0, irq_req}, 8'(1 << i));
            rd(2'd2, v); check($sformatf("R5 level lane%0d no flag", i), v, 8'h00);
            pins_in[i] = 1'b1;
            cyc(2); check($sformatf("R5 level lane%0d released", i), {4'h0, irq_req}, 8'h00);
        end
    endtask

    task automatic t_any();
        logic [7:0] v;
        wr(2'd0, 8'h55); wr(2'd2, 8'h0F); gie = 1'b1;
        for (int i = 0; i < NP; i++) begin
            wr(2'd1, 8'(1 << i));
            pins_in[i] = 1'b0;
            cyc(2); check($sformatf("R4 any lane%0d not yet", i), {4'h0, irq_req}, 8'h00);
            cyc(1); check($sformatf("R6 any lane%0d fall", i), {4'h0, irq_req}, 8'(1 << i));
            ack_vec = 4'(1 << i); cyc(1); ack_vec = '0;
            check($sformatf("R9 any lane%0d ack", i), {4'h0, irq_req}, 8'h00);
            pins_in[i] = 1'b1;
            cyc(3); check($sformatf("R6 any lane%0d rise", i), {4'h0, irq_req}, 8'(1 << i));
            wr(2'd2, 8'(1 << i));
            rd(2'd2, v); check($sformatf("R9 any lane%0d write clear", i), v, 8'h00);
        end
    endtask

    task automatic t_fall();
        logic [7:0] v;
        wr(2'd0, 8'hAA); gie = 1'b1;
        for (int i = 0; i < NP; i++) begin
            wr(2'd1, 8'(1 << i));
            pins_in[i] = 1'b0;
            cyc(3); check($sformatf("R7 fall lane%0d fall", i), {4'h0, irq_req}, 8'(1 << i));
            wr(2'd2, 8'h0F);
            pins_in[i] = 1'b1;
            cyc(4); rd(2'd2, v); check($sformatf("R7 fall lane%0d rise ignored", i), v, 8'h00);
        end
    endtask

    task automatic t_rise();
        logic [7:0] v;
        wr(2'd0, 8'hFF); gie = 1'b1;
        for (int i = 0; i < NP; i++) begin
            wr(2'd1, 8'(1 << i));
            pins_in[i] = 1'b0;
            cyc(4); rd(2'd2, v); check($sformatf("R7 rise lane%0d fall ignored", i), v, 8'h00);
            pins_in[i] = 1'b1;
            cyc(3); check($sformatf("R7 rise lane%0d rise", i), {4'h0, irq_req}, 8'(1 << i));
            wr(2'd2, 8'h0F);
        end
    endtask

    task automatic t_glitch();
        logic [7:0] v;
        wr(2'd0, 8'hFF); wr(2'd1, 8'h01); gie = 1'b1;
        pins_in[0] = 1'b0; cyc(4); wr(2'd2, 8'h0F);
        pins_in[0] = 1'b1; #(CLK_PERIOD/4); pins_in[0] = 1'b0;
        cyc(4); rd(2'd2, v); check("R8 sub-cycle glitch ignored", v, 8'h00);
        pins_in[0] = 1'b1; cyc(1); pins_in[0] = 1'b0;
        cyc(3); rd(2'd2, v); check("R8 one-cycle pulse caught", v, 8'h01);
        wr(2'd2, 8'h0F); pins_in[0] = 1'b1; cyc(4); wr(2'd2, 8'h0F);
    endtask

    task automatic t_mask_gie();
        logic [7:0] v;
        wr(2'd0, 8'hFF); wr(2'd1, 8'h00); gie = 1'b1;
        pins_in[1] = 1'b0; cyc(4); wr(2'd2, 8'h0F);
        pins_in[1] = 1'b1; cyc(3);
        check("R10 masked event no request", {4'h0, irq_req}, 8'h00);
        rd(2'd2, v); check("R10 masked event flagged", v, 8'h02);
        wr(2'd1, 8'h02);
        check("R10 unmask raises request", {4'h0, irq_req}, 8'h02);
        gie = 1'b0; #1;
        check("R10 global enable off", {4'h0, irq_req}, 8'h00);
        gie = 1'b1; #1;
        check("R10 global enable on", {4'h0, irq_req}, 8'h02);
        wr(2'd2, 8'h0F);
    endtask

    task automatic t_set_wins();
        logic [7:0] v;
        wr(2'd0, 8'hFF); wr(2'd1, 8'h04); gie = 1'b1;
        pins_in[2] = 1'b0; cyc(4); wr(2'd2, 8'h0F);
        pins_in[2] = 1'b1; cyc(2);
        ack_vec = 4'h4; cyc(1); ack_vec = '0;
        rd(2'd2, v); check("R9 event beats ack", v, 8'h04);
        pins_in[2] = 1'b0; cyc(4);
        pins_in[2] = 1'b1; cyc(2);
        wr(2'd2, 8'h04);
        rd(2'd2, v); check("R9 event beats write clear", v, 8'h04);
        wr(2'd2, 8'h0F);
    endtask

    task automatic t_mode_change();
        wr(2'd0, 8'h03); wr(2'd2, 8'h0F); gie = 1'b1;
        pins_in[0] = 1'b0; cyc(4); wr(2'd2, 8'h0F);
        wr(2'd1, 8'h01);
        check("R11 rising mode pin low quiet", {4'h0, irq_req}, 8'h00);
        wr(2'd0, 8'h00);
        check("R3 R11 switch to level request", {4'h0, irq_req}, 8'h01);
        pins_in[0] = 1'b1; cyc(2);
        check("R11 level released", {4'h0, irq_req}, 8'h00);
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        n_bad++;
        $display("FAIL watchdog R1 actual=hung expected=done");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        cyc(3);
        rst = 1'b0;
        cyc(1);
        t_reset();
        t_regs();
        t_level();
        t_any();
        t_fall();
        t_rise();
        t_glitch();
        t_mask_gie();
        t_set_wins();
        t_mode_change();
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule